// File: doc/BRIEF.md
# Instruction byte prefetch queue

This block sits between an instruction decoder and a byte-wide code memory. It keeps a window of up to 32 instruction bytes that starts at a recorded base address. The decoder asks for one, two or four bytes at the current instruction pointer. The block returns them packed little-endian and moves the pointer past them. A request that falls inside the window is answered from storage. A request outside it reloads the whole window, starting at the pointer.

When a hit leaves the pointer in the last few bytes of the window, the block slides the window. The unread bytes move to the front, the base moves to the new pointer, and only the missing tail is read from memory. Control-transfer opcodes, escape-page opcodes and illegal-opcode events arm a flush. The flush drops the window at the next instruction boundary, never partway through an instruction.

Top module: `pfq_prefetch_queue`

## Requirements
- R1: A delivered fetch returns the bytes at the pointer with the lowest address in bits 7:0. Size code 0 returns 1 byte, code 1 returns 2 bytes, and codes 2 and 3 return 4 bytes. Result bits above the returned bytes read zero.
- R2: The pointer advances by 1, 2 or 4 with each delivered fetch. A load while the block is not busy replaces the pointer with `ip_i`.
- R3: A fetch hits only when all of these hold: the window is valid, pointer >= base, and the fetch fits the window. A byte fits when pointer < base+S. A word fits when pointer+2 < base+S. A dword fits when pointer+4 < base+S. S is the window size. Any other fetch misses.
- R4: A miss reads S bytes from memory at addresses pointer, pointer+1, and so on upward. The base becomes the pointer. The data is delivered in the cycle after the last memory acknowledge.
- R5: Let P' be the pointer after a hit. If base+S-4 <= P' < base+S, then r = base+S-P' bytes are kept at the front of the window. The refill then reads only P'+r upward to the end of the window, and the base becomes P'.
- R6: A hit delivers its data one cycle after the request is accepted. A hit that does not slide makes no memory transfer.
- R7: A memory request stays high with a stable address until it is acknowledged. Each acknowledge transfers exactly one byte.
- R8: A flush is armed by these first opcode bytes: 0x70 through 0x7F, 0xE0 through 0xE3, 0xE8 through 0xEB, 0xC8 through 0xCF, 0xC2, 0xC3, 0x9A and 0xFF. Any opcode marked as escape-page arms it too. Marking an unlisted opcode disarms it. An instruction-start pulse clears the valid bit only while a flush is armed, and always disarms it.
- R9: An illegal-opcode pulse arms a flush, and it wins over an opcode mark in the same cycle.
- R10: The window size is taken from `win_size_i` and clamped to 8..32. It is sampled only while the window is invalid. A change made while the window is valid takes effect after the next flush.
- R11: After reset the window is invalid and no flush is armed. The pointer is zero, and `busy_o`, `rvalid_o` and `mem_req_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_req_i | input | 1 | Fetch request, accepted when busy_o is low |
| fetch_size_i | input | 2 | 0 byte, 1 word, 2 or 3 dword |
| busy_o | output | 1 | A reload or refill is in progress |
| rvalid_o | output | 1 | One-cycle pulse: rdata_o holds the fetch result |
| rdata_o | output | 32 | Fetched bytes, little-endian |
| ip_load_i | input | 1 | Replace the pointer with ip_i |
| ip_i | input | AW (32) | New pointer value |
| ip_o | output | AW (32) | Current instruction pointer |
| win_size_i | input | 6 | Requested window size in bytes |
| op_valid_i | input | 1 | Marks the first opcode byte of an instruction |
| op_byte_i | input | 8 | Opcode byte being marked |
| op_esc_i | input | 1 | Marked opcode is in the escape page |
| illegal_i | input | 1 | Illegal-opcode event |
| insn_start_i | input | 1 | Instruction boundary |
| mem_req_o | output | 1 | Memory byte read request |
| mem_addr_o | output | AW (32) | Memory byte address |
| mem_ack_i | input | 1 | Memory acknowledge, data valid |
| mem_data_i | input | 8 | Memory read byte |

## Verification
A hit raises `rvalid_o` at the accepting clock edge. The bench therefore samples the result at the falling edge right after that edge and fails the hit if the pulse comes any later. A miss raises `rvalid_o` at the edge of the final acknowledge. At that sample the bench requires the whole reload count to have been transferred. A slide delivers first and refills afterwards. The bench waits for `busy_o` to fall, then compares the number of transfers and the first refill address with its own window model. A flush shows only at the next fetch, so each flush check is a fetch that must or must not cause a reload.

// File: rtl/pfq_pkg.sv
package pfq_pkg;

  typedef enum logic [1:0] {
    FS_BYTE  = 2'd0,
    FS_WORD  = 2'd1,
    FS_DWORD = 2'd2,
    FS_DWALT = 2'd3
  } fsize_e;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_FILL = 1'b1
  } pfq_state_e;

  // opcodes that redirect the fetch stream
  function automatic logic is_flush_op(input logic [7:0] op, input logic esc);
    logic r;
    r = esc;
    if (op[7:4] == 4'h7)      r = 1'b1;
    if (op[7:3] == 5'b11001)  r = 1'b1;
    if (op[7:2] == 6'b111000) r = 1'b1;
    if (op[7:2] == 6'b111010) r = 1'b1;
    case (op)
      8'h9A, 8'hC2, 8'hC3, 8'hFF: r = 1'b1;
      default: ;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/pfq_lookup.sv
module pfq_lookup
  import pfq_pkg::*;
#(
  parameter int AW        = 32,
  parameter int MAX_Q     = 32,
  parameter int SLIDE_GAP = 4,
  localparam int SW       = $clog2(MAX_Q + 1),
  localparam int IW       = $clog2(MAX_Q)
) (
  input  logic [AW-1:0] ip_i,
  input  logic [AW-1:0] base_i,
  input  logic [SW-1:0] size_i,
  input  logic          valid_i,
  input  fsize_e        fsize_i,
  output logic          hit_o,
  output logic          slide_o,
  output logic [2:0]    step_o,
  output logic [IW-1:0] off_o,
  output logic [SW-1:0] keep_o,
  output logic [AW-1:0] next_ip_o
);

  logic [AW-1:0] off_full;
  logic [AW-1:0] noff;
  logic [AW-1:0] size_ext;
  logic [AW-1:0] margin;

  always_comb begin
    case (fsize_i)
      FS_BYTE: begin step_o = 3'd1; margin = '0;      end
      FS_WORD: begin step_o = 3'd2; margin = AW'(2);  end
      default: begin step_o = 3'd4; margin = AW'(4);  end
    endcase
  end

  assign size_ext  = AW'(size_i);
  assign off_full  = ip_i - base_i;
  assign noff      = off_full + AW'(step_o);
  assign next_ip_o = ip_i + AW'(step_o);
  assign off_o     = off_full[IW-1:0];

  assign hit_o   = valid_i && (ip_i >= base_i) && (off_full < size_ext - margin);
  assign slide_o = hit_o && (noff + AW'(SLIDE_GAP) >= size_ext) && (noff < size_ext);
  assign keep_o  = SW'(size_ext - noff);

endmodule

// File: rtl/pfq_flush_ctl.sv
module pfq_flush_ctl
  import pfq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       op_valid_i,
  input  logic [7:0] op_byte_i,
  input  logic       op_esc_i,
  input  logic       illegal_i,
  input  logic       start_i,
  output logic       flush_o
);

  logic pend_q;
  logic op_hit;

  assign op_hit  = is_flush_op(op_byte_i, op_esc_i);
  assign flush_o = start_i && pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
    end else begin
      if (start_i)    pend_q <= 1'b0;
      if (op_valid_i) pend_q <= op_hit;
      if (illegal_i)  pend_q <= 1'b1;
    end
  end

  AST_MARK_ARMS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i && op_hit |=> pend_q) else $error("mark did not arm"); // R8
  AST_PLAIN_DISARMS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i && !op_hit && !illegal_i |=> !pend_q) else $error("plain op kept armed"); // R8
  AST_ILLEGAL_ARMS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_i |=> pend_q) else $error("illegal did not arm"); // R9

endmodule

// File: rtl/pfq_prefetch_queue.sv
module pfq_prefetch_queue
  import pfq_pkg::*;
#(
  parameter int AW        = 32,
  parameter int MAX_Q     = 32,
  parameter int MIN_Q     = 8,
  parameter int SLIDE_GAP = 4,
  localparam int SW       = $clog2(MAX_Q + 1),
  localparam int IW       = $clog2(MAX_Q)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fetch_req_i,
  input  logic [1:0]    fetch_size_i,
  output logic          busy_o,
  output logic          rvalid_o,
  output logic [31:0]   rdata_o,
  input  logic          ip_load_i,
  input  logic [AW-1:0] ip_i,
  output logic [AW-1:0] ip_o,
  input  logic [SW-1:0] win_size_i,
  input  logic          op_valid_i,
  input  logic [7:0]    op_byte_i,
  input  logic          op_esc_i,
  input  logic          illegal_i,
  input  logic          insn_start_i,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic          mem_ack_i,
  input  logic [7:0]    mem_data_i
);

  pfq_state_e    state_q;
  logic          valid_q;
  logic [AW-1:0] base_q;
  logic [SW-1:0] size_q;
  logic [AW-1:0] ip_q;
  logic [SW-1:0] fill_idx_q;
  logic          deliver_q;
  logic [2:0]    dstep_q;
  logic [7:0]    qbuf [MAX_Q];

  logic          idle;
  logic          flush_w;
  logic [AW-1:0] ip_cur;
  logic [SW-1:0] size_clamp;
  logic          lk_hit, lk_slide;
  logic [2:0]    lk_step;
  logic [IW-1:0] lk_off;
  logic [SW-1:0] lk_keep;
  logic [AW-1:0] lk_next;
  logic          accept;
  logic          do_slide;
  logic          fill_wr;
  logic          fill_last;
  logic [IW-1:0] pick_base;
  logic [2:0]    pick_step;
  logic [7:0]    pick_b [4];
  logic [31:0]   pick_word;

  assign idle       = (state_q == ST_IDLE);
  assign busy_o     = !idle;
  assign mem_req_o  = (state_q == ST_FILL);
  assign mem_addr_o = base_q + AW'(fill_idx_q);
  assign ip_o       = ip_q;
  assign ip_cur     = (ip_load_i && idle) ? ip_i : ip_q;
  assign accept     = fetch_req_i && idle;
  assign do_slide   = accept && lk_hit && lk_slide;
  assign fill_wr    = (state_q == ST_FILL) && mem_ack_i;
  assign fill_last  = fill_idx_q == size_q - SW'(1);

  always_comb begin
    if (win_size_i < SW'(MIN_Q))      size_clamp = SW'(MIN_Q);
    else if (win_size_i > SW'(MAX_Q)) size_clamp = SW'(MAX_Q);
    else                              size_clamp = win_size_i;
  end

  pfq_flush_ctl u_flush (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .op_valid_i (op_valid_i),
    .op_byte_i  (op_byte_i),
    .op_esc_i   (op_esc_i),
    .illegal_i  (illegal_i),
    .start_i    (insn_start_i && idle),
    .flush_o    (flush_w)
  );

  pfq_lookup #(
    .AW        (AW),
    .MAX_Q     (MAX_Q),
    .SLIDE_GAP (SLIDE_GAP)
  ) u_lookup (
    .ip_i      (ip_cur),
    .base_i    (base_q),
    .size_i    (size_q),
    .valid_i   (valid_q && !flush_w),
    .fsize_i   (fsize_e'(fetch_size_i)),
    .hit_o     (lk_hit),
    .slide_o   (lk_slide),
    .step_o    (lk_step),
    .off_o     (lk_off),
    .keep_o    (lk_keep),
    .next_ip_o (lk_next)
  );

  // byte selection: hit reads at the offset, reload completion reads from slot 0
  assign pick_base = idle ? lk_off : '0;
  assign pick_step = idle ? lk_step : dstep_q;

  always_comb begin
    for (int k = 0; k < 4; k++) begin
      pick_b[k] = qbuf[IW'(int'(pick_base) + k)];
    end
    case (pick_step)
      3'd1:    pick_word = {24'h0, pick_b[0]};
      3'd2:    pick_word = {16'h0, pick_b[1], pick_b[0]};
      default: pick_word = {pick_b[3], pick_b[2], pick_b[1], pick_b[0]};
    endcase
  end

  // window storage, no reset needed
  always_ff @(posedge clk_i) begin
    if (do_slide) begin
      for (int i = 0; i < SLIDE_GAP; i++) begin
        if (SW'(i) < lk_keep) qbuf[i] <= qbuf[IW'(int'(lk_off) + int'(lk_step) + i)];
      end
    end
    if (fill_wr) qbuf[fill_idx_q[IW-1:0]] <= mem_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      valid_q    <= 1'b0;
      base_q     <= '0;
      size_q     <= SW'(MIN_Q);
      ip_q       <= '0;
      fill_idx_q <= '0;
      deliver_q  <= 1'b0;
      dstep_q    <= 3'd1;
      rvalid_o   <= 1'b0;
      rdata_o    <= '0;
    end else begin
      rvalid_o <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (!valid_q) size_q <= size_clamp;
          if (flush_w) valid_q <= 1'b0;
          if (ip_load_i) ip_q <= ip_i;
          if (fetch_req_i) begin
            if (lk_hit) begin
              rdata_o  <= pick_word;
              rvalid_o <= 1'b1;
              ip_q     <= lk_next;
              if (lk_slide) begin
                base_q     <= lk_next;
                fill_idx_q <= lk_keep;
                deliver_q  <= 1'b0;
                state_q    <= ST_FILL;
              end
            end else begin
              if (valid_q && !flush_w) size_q <= size_q;
              else                     size_q <= size_clamp;
              valid_q    <= 1'b0;
              base_q     <= ip_cur;
              ip_q       <= ip_cur;
              fill_idx_q <= '0;
              deliver_q  <= 1'b1;
              dstep_q    <= lk_step;
              state_q    <= ST_FILL;
            end
          end
        end
        default: begin
          if (mem_ack_i) begin
            if (fill_last) begin
              state_q <= ST_IDLE;
              valid_q <= 1'b1;
              if (deliver_q) begin
                rdata_o  <= pick_word;
                rvalid_o <= 1'b1;
                ip_q     <= ip_q + AW'(dstep_q);
              end
            end else begin
              fill_idx_q <= fill_idx_q + SW'(1);
            end
          end
        end
      endcase
    end
  end

  AST_MEM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o)) else $error("request dropped"); // R7
  AST_FILL_IN_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_addr_o - base_q) < AW'(size_q)) else $error("fill outside window"); // R4
  AST_SIZE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q && $past(valid_q) |-> $stable(size_q)) else $error("size moved while valid"); // R10
  AST_SIZE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    size_q >= SW'(MIN_Q) && size_q <= SW'(MAX_Q)) else $error("size out of range"); // R10
  AST_FLUSH_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_w && !fetch_req_i |=> !valid_q) else $error("flush kept window"); // R8
  AST_HIT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && lk_hit && !lk_slide |=> !mem_req_o && rvalid_o) else $error("hit not immediate"); // R6

endmodule

// File: tb/pfq_prefetch_queue_bench.sv
module pfq_prefetch_queue_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_req = 1'b0;
  logic [1:0]  fetch_size = 2'd0;
  logic        busy, rvalid;
  logic [31:0] rdata;
  logic        ip_load = 1'b0;
  logic [31:0] ip_in = '0;
  logic [31:0] ip_out;
  logic [5:0]  win_size = 6'd16;
  logic        op_valid = 1'b0;
  logic [7:0]  op_byte = '0;
  logic        op_esc = 1'b0;
  logic        illegal = 1'b0;
  logic        insn_start = 1'b0;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_ack = 1'b0;
  logic [7:0]  mem_data = '0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int xfer_cnt = 0;
  logic [31:0] first_addr = '0;

  // reference model
  logic        m_valid = 1'b0;
  logic        m_pend = 1'b0;
  logic [31:0] m_base = '0;
  logic [31:0] m_ip = '0;
  int          m_size = 8;
  int          m_win = 16;

  always #5 clk = ~clk;

  pfq_prefetch_queue u_pfq_prefetch_queue (
    .clk_i (clk), .rst_ni (rst_n),
    .fetch_req_i (fetch_req), .fetch_size_i (fetch_size),
    .busy_o (busy), .rvalid_o (rvalid), .rdata_o (rdata),
    .ip_load_i (ip_load), .ip_i (ip_in), .ip_o (ip_out),
    .win_size_i (win_size),
    .op_valid_i (op_valid), .op_byte_i (op_byte), .op_esc_i (op_esc),
    .illegal_i (illegal), .insn_start_i (insn_start),
    .mem_req_o (mem_req), .mem_addr_o (mem_addr),
    .mem_ack_i (mem_ack), .mem_data_i (mem_data)
  );

  function automatic logic [7:0] mb(input logic [31:0] a);
    return (a[7:0] * 8'd29) ^ a[15:8] ^ 8'h5A;
  endfunction

  function automatic int clampm(input int v);
    if (v < 8) return 8;
    if (v > 32) return 32;
    return v;
  endfunction

  function automatic logic listed(input logic [7:0] op, input logic esc);
    if (esc) return 1'b1;
    if (op >= 8'h70 && op <= 8'h7F) return 1'b1;
    if (op >= 8'hC8 && op <= 8'hCF) return 1'b1;
    if (op >= 8'hE0 && op <= 8'hE3) return 1'b1;
    if (op >= 8'hE8 && op <= 8'hEB) return 1'b1;
    return (op == 8'h9A) || (op == 8'hC2) || (op == 8'hC3) || (op == 8'hFF);
  endfunction

  task automatic chk(input logic ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  // memory responder
  initial begin : responder
    forever begin
      @(negedge clk);
      if (mem_req && ($urandom % 3 != 0)) begin
        mem_ack = 1'b1;
        mem_data = mb(mem_addr);
        if (xfer_cnt == 0) first_addr = mem_addr;
        xfer_cnt++;
      end else begin
        mem_ack = 1'b0;
      end
    end
  end

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 5000) begin @(negedge clk); n++; end
  endtask

  task automatic set_ip(input logic [31:0] a);
    wait_idle();
    ip_load = 1'b1; ip_in = a;
    @(posedge clk); @(negedge clk);
    ip_load = 1'b0;
    m_ip = a;
    chk(ip_out == a, "R2", "pointer load", ip_out, a);
  endtask

  task automatic set_win(input int v);
    @(negedge clk);
    win_size = 6'(v);
    m_win = v;
  endtask

  task automatic mark(input logic [7:0] op, input logic esc, input logic ill);
    wait_idle();
    op_valid = 1'b1; op_byte = op; op_esc = esc; illegal = ill;
    @(posedge clk); @(negedge clk);
    op_valid = 1'b0; illegal = 1'b0; op_esc = 1'b0;
    m_pend = ill ? 1'b1 : listed(op, esc);
  endtask

  task automatic start_insn();
    wait_idle();
    insn_start = 1'b1;
    @(posedge clk); @(negedge clk);
    insn_start = 1'b0;
    if (m_pend) m_valid = 1'b0;
    m_pend = 1'b0;
  endtask

  task automatic fetch(input logic [1:0] sz, input string tag);
    int n, margin, off, noff, r, exp_x, lat;
    logic hit, slide;
    logic [31:0] exp_d, exp_first;
    n = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    margin = (sz == 2'd0) ? 0 : n;
    off = int'(m_ip - m_base);
    hit = m_valid && (m_ip >= m_base) && (m_ip - m_base < 32'(m_size - margin));
    slide = 1'b0; exp_x = 0; exp_first = '0;
    if (hit) begin
      noff = off + n;
      if (noff + 4 >= m_size && noff < m_size) begin
        slide = 1'b1;
        r = m_size - noff;
        exp_x = m_size - r;
        exp_first = m_ip + 32'(n) + 32'(r);
        m_base = m_ip + 32'(n);
      end
    end else begin
      if (!m_valid) m_size = clampm(m_win);
      exp_x = m_size;
      exp_first = m_ip;
      m_base = m_ip;
      m_valid = 1'b1;
    end
    exp_d = '0;
    for (int k = 0; k < n; k++) exp_d[8*k +: 8] = mb(m_ip + 32'(k));
    m_ip = m_ip + 32'(n);

    wait_idle();
    xfer_cnt = 0;
    fetch_req = 1'b1; fetch_size = sz;
    @(posedge clk); @(negedge clk);
    fetch_req = 1'b0;
    lat = 1;
    while (!rvalid && lat < 3000) begin @(negedge clk); lat++; end
    chk(rvalid, "R1", "no result pulse", 32'(rvalid), 32'd1);
    chk(rdata == exp_d, "R1", "fetch data", rdata, exp_d);
    if (hit) chk(lat == 1, "R6", "hit latency", 32'(lat), 32'd1);
    else     chk(xfer_cnt == exp_x, "R4", "reload done before data", 32'(xfer_cnt), 32'(exp_x));
    wait_idle();
    chk(xfer_cnt == exp_x, tag, "memory transfers", 32'(xfer_cnt), 32'(exp_x));
    if (exp_x > 0)
      chk(first_addr == exp_first, slide ? "R5" : "R4", "first fill address", first_addr, exp_first);
    chk(ip_out == m_ip, "R2", "pointer advance", ip_out, m_ip);
  endtask

  initial begin : main
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(!busy && !rvalid && !mem_req, "R11", "idle after reset", {29'h0, busy, rvalid, mem_req}, 32'h0);
    chk(ip_out == 32'h0, "R11", "pointer after reset", ip_out, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // first fetch must reload: window invalid after reset
    set_win(16);
    fetch(2'd0, "R11");
    set_ip(32'h100);
    fetch(2'd0, "R3");
    fetch(2'd1, "R3");
    fetch(2'd2, "R3");
    fetch(2'd3, "R3");
    fetch(2'd1, "R5");
    fetch(2'd2, "R5");
    // straddle the end: dword at base+13 misses
    set_ip(m_base + 32'd13);
    fetch(2'd2, "R3");
    // below base, misaligned
    set_ip(m_base - 32'd1);
    fetch(2'd1, "R3");
    fetch(2'd0, "R3");

    // size change while valid is deferred
    set_win(40);
    set_ip(m_base + 32'd200);
    fetch(2'd0, "R10");
    mark(8'hEB, 1'b0, 1'b0);
    start_insn();
    fetch(2'd0, "R10");
    set_win(3);
    mark(8'hC3, 1'b0, 1'b0);
    start_insn();
    fetch(2'd2, "R10");

    // flush sweep
    set_win(8);
    for (int op = 0; op < 256; op++) begin
      mark(8'(op), 1'b0, 1'b0);
      start_insn();
      fetch(2'd0, "R8");
    end
    mark(8'h05, 1'b1, 1'b0);
    start_insn();
    fetch(2'd0, "R8");
    mark(8'h70, 1'b0, 1'b0);
    mark(8'h90, 1'b0, 1'b0);
    start_insn();
    fetch(2'd0, "R8");
    mark(8'h90, 1'b0, 1'b1);
    start_insn();
    fetch(2'd0, "R9");
    start_insn();
    fetch(2'd0, "R8");

    // random mix
    set_win(20);
    for (int it = 0; it < 700; it++) begin
      int sel;
      sel = int'($urandom % 100);
      if (sel < 70) fetch(2'($urandom % 4), "R3");
      else if (sel < 80) set_ip(m_ip + 32'($urandom % 24) - 32'd8);
      else if (sel < 90) begin mark(8'($urandom), 1'($urandom % 8 == 0), 1'b0); start_insn(); end
      else if (sel < 95) begin mark(8'($urandom), 1'b0, 1'b1); start_insn(); end
      else set_win(int'($urandom % 40));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule